// File: doc/BRIEF.md
# Auto-Clocked I2S Slave Serial Transmitter

This block sends stereo 24-bit sample pairs out on a single serial data line in I2S format, as a pure slave. The master clock and the left/right frame clock both come from outside, and there is no bit clock pin. The block counts master-clock cycles over each frame-clock period, decides whether the master clock runs at 256 or 128 times the sample rate, and from that builds an internal bit clock of 64 times the sample rate. Each channel slot is 32 bit periods long: one lead-in period, 24 data bits MSB first, then 7 unused periods driven low.

A new sample pair is offered on a parallel port with a one-cycle valid strobe; the latest pair offered before a frame starts (falling frame clock, left half) is the one sent in that frame. If no new pair arrives, the previous pair is sent again. When the measured frame period fits neither ratio, or the frame clock stops, the block reports loss of lock and holds the data line low. The whole block runs in the master-clock domain; while the master clock is absent the system holds it in reset.

Top module: `i2s_autoclk_tx`

## Requirements
- R1: While reset is asserted and after its release, sdata is 0 and unlocked is 1 until lock is gained.
- R2: A frame period measured at 248 to 264 master-clock cycles classifies as ratio 256, giving bit periods of 4 master-clock cycles.
- R3: A frame period measured at 120 to 136 master-clock cycles classifies as ratio 128, giving bit periods of 2 master-clock cycles.
- R4: Lock is gained only at a falling frame-clock edge where the period just ended and the one before it both classify as the same ratio; a period fitting neither ratio drops lock at the next falling edge; while unlocked, unlocked is 1 and sdata is 0.
- R5: Taking P0 as the first rising master-clock edge after a frame-clock change and D the bit period, slot k of that half is driven on sdata from edge P(D*k+2) to P(D*k+D+2); slot 0 is 0, slots 1 to 24 carry bits 23 down to 0, slots 25 to 31 are 0.
- R6: Frame clock low carries the left word, frame clock high carries the right word.
- R7: The pair sent in a frame is the last pair strobed in before that frame's falling frame-clock edge; with no new strobe the previous pair is sent again, and the words hold for the whole frame.
- R8: If the frame clock stops so that more than 264 master-clock cycles pass without a falling edge, lock drops at once and sdata goes low.
- R9: A pair strobed in during the left half does not change the right word of the current frame; it is sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, the block's only clock |
| rst_n | input | 1 | Active-low asynchronous reset, held while mclk is absent |
| lrclk | input | 1 | Frame clock: low = left half, high = right half |
| smp_valid | input | 1 | One-cycle strobe accepting smp_left and smp_right |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| sdata | output | 1 | Serial data out |
| unlocked | output | 1 | 1 while no clock ratio is locked |

## Verification
The bench aims at the lock window edges (periods of 248 and 264 lock, 272 and an off-grid 200 do not) and at the two-match rule, where a design locking after one good count would send data one frame early. It checks the lead-in slot and the trailing gap slots, where an off-by-one bit counter shows up as a shifted word, and switches from ratio 256 to 128 to catch a divider stuck on one ratio. It repeats a pair without a new strobe and strobes a pair mid-frame, which a design loading words at the wrong moment would send in the wrong half. A stalled frame clock must drop lock, where a saturating or wrapping counter that never times out would keep driving stale data.

// File: rtl/i2s_autoclk_tx.sv
module i2s_autoclk_tx #(
  parameter int W   = 24,
  parameter int HI  = 256,
  parameter int LO  = 128,
  parameter int TOL = 8,
  parameter int CW  = 10
) (
  input  logic         mclk,
  input  logic         rst_n,
  input  logic         lrclk,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  output logic         sdata,
  output logic         unlocked
);
  localparam logic [CW-1:0] CMAX   = '1;
  localparam logic [CW:0]   HI_MIN = (CW+1)'(HI - TOL);
  localparam logic [CW:0]   HI_MAX = (CW+1)'(HI + TOL);
  localparam logic [CW:0]   LO_MIN = (CW+1)'(LO - TOL);
  localparam logic [CW:0]   LO_MAX = (CW+1)'(LO + TOL);
  localparam logic [4:0]    WL     = 5'(W);

  logic          lr_q1, lr_q2;
  logic [CW-1:0] cnt;
  logic [7:0]    hc;
  logic [1:0]    code, prev_code;
  logic          locked, mode_lo;
  logic [W-1:0]  pend_l, pend_r, act_l, act_r, wsel;
  logic [CW:0]   meas;
  logic [4:0]    slot;
  logic          in_half, nxt;

  wire lr_edge = lr_q1 ^ lr_q2;
  wire fall    = lr_q2 & ~lr_q1;

  assign meas = {1'b0, cnt} + 1'b1;
  assign code = (meas >= HI_MIN && meas <= HI_MAX) ? 2'd1 :
                (meas >= LO_MIN && meas <= LO_MAX) ? 2'd2 : 2'd0;
  assign slot    = mode_lo ? hc[5:1] : hc[6:2];
  assign in_half = mode_lo ? (hc[7:6] == 2'b00) : ~hc[7];
  assign wsel    = lr_q2 ? act_r : act_l;
  assign unlocked = ~locked;

  always_comb begin
    nxt = 1'b0;
    if (locked && in_half && slot >= 5'd1 && slot <= WL)
      nxt = wsel[WL - slot];
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q1 <= 1'b0;  lr_q2 <= 1'b0;
      cnt <= '0;      hc <= '0;
      prev_code <= '0; locked <= 1'b0; mode_lo <= 1'b0;
      pend_l <= '0;   pend_r <= '0;
      act_l <= '0;    act_r <= '0;
      sdata <= 1'b0;
    end else begin
      lr_q1 <= lrclk;
      lr_q2 <= lr_q1;
      if (fall) cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
      if (lr_edge) hc <= '0;
      else if (hc != 8'hFF) hc <= hc + 1'b1;
      if (fall) begin
        locked    <= (code != 2'd0) && (code == prev_code);
        mode_lo   <= (code == 2'd2);
        prev_code <= code;
      end else if ({1'b0, cnt} > HI_MAX) begin
        locked <= 1'b0;
      end
      if (smp_valid) begin
        pend_l <= smp_left;
        pend_r <= smp_right;
      end
      if (fall) begin
        act_l <= pend_l;
        act_r <= pend_r;
      end
      sdata <= nxt;
    end
  end

  assert_idle_unlocked_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    !locked |=> !sdata);
  assert_lock_on_edge_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked) |-> $past(fall));
  assert_word_hold_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    !fall |=> ($stable(act_l) && $stable(act_r)));
  assert_gap_zero_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    (slot == 5'd0 || slot > WL) |=> !sdata);
endmodule

// File: tb/tb_i2s_autoclk_tx.sv
`timescale 1ns/1ps
module tb_i2s_autoclk_tx;
  logic mclk = 1'b0, rst_n = 1'b0, lrclk = 1'b1, smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic sdata, unlocked;
  int checks = 0, errors = 0;
  bit done = 0;

  int last_n = 0, b_prev = 0;
  bit b_locked = 0, b_lo = 0;
  logic [23:0] b_pend_l = '0, b_pend_r = '0, b_act_l = '0, b_act_r = '0;

  always #2 mclk = ~mclk;

  i2s_autoclk_tx dut (.mclk(mclk), .rst_n(rst_n), .lrclk(lrclk), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .sdata(sdata), .unlocked(unlocked));

  function automatic int classify(int n);
    if (n >= 248 && n <= 264) return 1;
    if (n >= 120 && n <= 136) return 2;
    return 0;
  endfunction

  function automatic logic exp_bit(logic [23:0] w, int k, bit lk);
    if (!lk || k < 1 || k > 24) return 1'b0;
    return w[24-k];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_frame(string tag, int n, bit nxt, logic [23:0] nl, logic [23:0] nr,
                          bit mid, logic [23:0] ml, logic [23:0] mr);
    int code, d, half, q, k;
    code = classify(last_n);
    b_locked = (code != 0) && (code == b_prev);
    b_prev = code;
    b_lo = (code == 2);
    b_act_l = b_pend_l;
    b_act_r = b_pend_r;
    d = b_lo ? 2 : 4;
    half = n / 2;
    for (int h = 0; h < 2; h++) begin
      lrclk = (h == 1);
      for (int p = 0; p < half; p++) begin
        @(posedge mclk);
        @(negedge mclk);
        smp_valid = 1'b0;
        q = p - 2 - d / 2;
        if (q >= 0 && q % d == 0 && q / d <= 27) begin
          k = q / d;
          chk(tag, sdata, exp_bit(h == 1 ? b_act_r : b_act_l, k, b_locked));
          chk({tag, "/R4 unlocked"}, unlocked, !b_locked);
        end
        if (p == 10 && ((h == 1 && nxt) || (h == 0 && mid))) begin
          smp_valid = 1'b1;
          smp_left  = (h == 1) ? nl : ml;
          smp_right = (h == 1) ? nr : mr;
          b_pend_l = smp_left;
          b_pend_r = smp_right;
        end
      end
    end
    last_n = n;
  endtask

  task automatic stall(int cyc);
    repeat (cyc) @(negedge mclk);
    last_n = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge mclk);
    chk("R1 sdata in reset", sdata, 1'b0);
    chk("R1 unlocked in reset", unlocked, 1'b1);
    rst_n = 1'b1;
    repeat (10) @(negedge mclk);
    chk("R1 sdata after reset", sdata, 1'b0);
    chk("R1 unlocked after reset", unlocked, 1'b1);
    // R4: first two frames stay unlocked, third locks
    do_frame("R4", 256, 1, 24'hA5C33C, 24'h0F1E2D, 0, '0, '0);
    do_frame("R4", 256, 0, '0, '0, 0, '0, '0);
    chk("R4 still unlocked after one match", unlocked, 1'b1);
    do_frame("R2", 256, 1, 24'h800001, 24'h7FFFFE, 0, '0, '0);
    // R2/R5/R6 random frames with jitter inside the window
    for (int i = 0; i < 6; i++)
      do_frame("R2/R5/R6", 248 + 2 * int'($urandom % 9), 1, 24'($urandom), 24'($urandom), 0, '0, '0);
    // R7 repeat without strobe
    do_frame("R7 repeat", 256, 0, '0, '0, 0, '0, '0);
    // R9 strobe mid-frame in left half
    do_frame("R9 mid strobe", 256, 0, '0, '0, 1, 24'hFFFFFF, 24'h123456);
    do_frame("R9 next frame", 256, 0, '0, '0, 0, '0, '0);
    // R2 window edges
    do_frame("R2 edge264", 264, 1, 24'h5A5A5A, 24'hC0FFEE, 0, '0, '0);
    do_frame("R2 edge248", 248, 1, 24'h000001, 24'h800000, 0, '0, '0);
    do_frame("R2 edge248", 248, 1, 24'($urandom), 24'($urandom), 0, '0, '0);
    // R4 out of window period drops lock
    do_frame("R4 272", 272, 1, 24'h111111, 24'h222222, 0, '0, '0);
    do_frame("R4 after 272", 256, 0, '0, '0, 0, '0, '0);
    do_frame("R4 relock1", 200, 0, '0, '0, 0, '0, '0);
    do_frame("R4 after 200", 256, 0, '0, '0, 0, '0, '0);
    do_frame("R4 relock", 256, 0, '0, '0, 0, '0, '0);
    do_frame("R4 locked", 256, 1, 24'h3C3C3C, 24'hE7E7E7, 0, '0, '0);
    // R3 switch to ratio 128
    for (int i = 0; i < 6; i++)
      do_frame("R3", 120 + 2 * int'($urandom % 9), 1, 24'($urandom), 24'($urandom), 0, '0, '0);
    do_frame("R3 edge136", 136, 1, 24'hABCDEF, 24'h654321, 0, '0, '0);
    do_frame("R3 edge120", 120, 1, 24'hFEDCBA, 24'h000F00, 0, '0, '0);
    // R8 stalled frame clock
    stall(400);
    chk("R8 unlocked after stall", unlocked, 1'b1);
    chk("R8 sdata low after stall", sdata, 1'b0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule